// File: doc/BRIEF.md
# Bayer Raw Black Offset Subtractor

This block is a streaming correction stage for 10-bit Bayer raw video. Pixels enter on an AXI4-Stream slave port and leave on an AXI4-Stream master port. Each pixel has the black offset of its colour site removed. The four sites are red, blue, green-on-red-row and green-on-blue-row. The site is found from the parity of the pixel's row and column together with a two-bit pattern code. If the offset is larger than the pixel value, the result saturates at zero.

The block counts position itself. It uses the programmed frame width and height, and `tuser` marks the start of a frame. The sideband bits `tuser` and `tlast` travel through the one-stage pipeline in step with their pixel. Backpressure on the output stalls the stage, and no pixel is lost or repeated. The offsets, the pattern code and the frame size are static configuration inputs. They are expected to change only while the stream is idle.

Top module: `bayer_black_sub`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `m_tvalid` is 0.
- R2: Every pixel accepted on the input (`s_tvalid && s_tready` at a rising edge) appears on `m_tdata` with `m_tvalid` high from the next cycle on. Its value is max(pixel − offset of its site, 0). For example, input 28 with offset 10 gives 18.
- R3: When the site offset is greater than or equal to the pixel value, the output is 0. It never wraps to a large value.
- R4: Take the site index as {row[0], col[0]}. Pattern 0 maps index 0,1,2,3 to R,Gr,Gb,B. Pattern 1 maps them to Gr,R,B,Gb. Pattern 2 maps them to Gb,B,R,Gr. Pattern 3 maps them to B,Gb,Gr,R. Row 0, column 0 is the top-left pixel.
- R5: When all four offsets are zero, each output pixel equals its input pixel.
- R6: A pixel accepted with `s_tuser` high is taken as row 0, column 0, wherever the counters stood.
- R7: The column advances on each accepted pixel and returns to 0 after column `cfg_width`−1; the row then advances. After row `cfg_height`−1 the row returns to 0, even when no `tuser` arrives.
- R8: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata`, `m_tuser` and `m_tlast` hold their values. `s_tready` is high exactly when the output stage is empty or is being read. Pixels leave in the order they arrived, each exactly once.
- R9: `m_tuser` and `m_tlast` carry the `s_tuser` and `s_tlast` values of the same pixel as `m_tdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 16 | Pixels per line |
| cfg_height | input | 16 | Lines per frame |
| cfg_pattern | input | 2 | Colour pattern code (see R4) |
| cfg_lvl_r | input | 10 | Offset for red sites |
| cfg_lvl_gr | input | 10 | Offset for green sites on red rows |
| cfg_lvl_gb | input | 10 | Offset for green sites on blue rows |
| cfg_lvl_b | input | 10 | Offset for blue sites |
| s_tdata | input | 10 | Input pixel |
| s_tvalid | input | 1 | Input pixel valid |
| s_tready | output | 1 | Block can take a pixel |
| s_tuser | input | 1 | Start of frame |
| s_tlast | input | 1 | End of line |
| m_tdata | output | 10 | Corrected pixel |
| m_tvalid | output | 1 | Output pixel valid |
| m_tready | input | 1 | Downstream can take a pixel |
| m_tuser | output | 1 | Start of frame, aligned with m_tdata |
| m_tlast | output | 1 | End of line, aligned with m_tdata |

## Verification
An accepted input pixel is due on the output port exactly one cycle after the edge that accepted it. It stays there until the first edge at which `m_tready` is high. The bench computes each expected pixel at the moment of acceptance, from its own position counters and site table, and puts it in an ordered queue. It drives inputs and samples outputs just after each falling edge, so the output handshake about to happen is seen before the new input is queued. It compares the head of the queue only on cycles where `m_tvalid` and `m_tready` are both high. A stalled output is compared against its value from the previous cycle.

// File: rtl/bayer_black_sub_pkg.sv
package bayer_black_sub_pkg;

    // Canonical site order used inside the block (pattern code 0 layout):
    // index {row parity, column parity}
    localparam int unsigned SITE_CNT = 4;
    localparam logic [1:0] SITE_R  = 2'd0;
    localparam logic [1:0] SITE_GR = 2'd1;
    localparam logic [1:0] SITE_GB = 2'd2;
    localparam logic [1:0] SITE_B  = 2'd3;

    typedef struct packed {
        logic [15:0] col;
        logic [15:0] row;
    } pos_t;

    typedef struct packed {
        logic       valid;
        logic       user;
        logic       last;
        logic [9:0] data;
    } beat_t;

endpackage

// File: rtl/bbs_position.sv
module bbs_position #(
    parameter int DIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             sof,
    input  logic [DIM_W-1:0] cfg_width,
    input  logic [DIM_W-1:0] cfg_height,
    output logic             row_par,
    output logic             col_par
);
    localparam int EXT_W = DIM_W + 1;

    typedef struct packed {
        logic [DIM_W-1:0] col;
        logic [DIM_W-1:0] row;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [DIM_W-1:0] cur_col, cur_row;
    logic [EXT_W-1:0] col_inc, row_inc;

    always_comb begin
        cur_col = sof ? '0 : cnt_q.col;
        cur_row = sof ? '0 : cnt_q.row;
        col_inc = {1'b0, cur_col} + EXT_W'(1);
        row_inc = {1'b0, cur_row} + EXT_W'(1);
        cnt_d   = cnt_q;
        if (accept) begin
            if (col_inc >= {1'b0, cfg_width}) begin
                cnt_d.col = '0;
                cnt_d.row = (row_inc >= {1'b0, cfg_height}) ? '0 : row_inc[DIM_W-1:0];
            end else begin
                cnt_d.col = col_inc[DIM_W-1:0];
                cnt_d.row = cur_row;
            end
        end
        row_par = cur_row[0];
        col_par = cur_col[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6: a start-of-frame pixel sits at column 0, so the next one is column 1
    assert_sof_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && sof && cfg_width > DIM_W'(1))
        |=> (cnt_q.col == DIM_W'(1) && cnt_q.row == '0));

endmodule

// File: rtl/bbs_site_pick.sv
module bbs_site_pick #(
    parameter int PIX_W = 10
) (
    input  logic [1:0]       pattern,
    input  logic             row_par,
    input  logic             col_par,
    input  logic [PIX_W-1:0] lvl_r,
    input  logic [PIX_W-1:0] lvl_gr,
    input  logic [PIX_W-1:0] lvl_gb,
    input  logic [PIX_W-1:0] lvl_b,
    output logic [PIX_W-1:0] level
);
    import bayer_black_sub_pkg::*;

    logic [1:0]       site;
    logic [PIX_W-1:0] lvl_tab [SITE_CNT];
    logic [PIX_W-1:0] masked  [SITE_CNT];

    // Each pattern is the base layout shifted by one row and/or column.
    assign site = {row_par ^ pattern[1], col_par ^ pattern[0]};

    assign lvl_tab[SITE_R]  = lvl_r;
    assign lvl_tab[SITE_GR] = lvl_gr;
    assign lvl_tab[SITE_GB] = lvl_gb;
    assign lvl_tab[SITE_B]  = lvl_b;

    for (genvar s = 0; s < SITE_CNT; s++) begin : g_site
        assign masked[s] = (site == 2'(s)) ? lvl_tab[s] : '0;
    end

    always_comb begin
        level = '0;
        for (int s = 0; s < SITE_CNT; s++) level = level | masked[s];
    end

endmodule

// File: rtl/bayer_black_sub.sv
module bayer_black_sub #(
    parameter int PIX_W = 10,
    parameter int DIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIM_W-1:0] cfg_width,
    input  logic [DIM_W-1:0] cfg_height,
    input  logic [1:0]       cfg_pattern,
    input  logic [PIX_W-1:0] cfg_lvl_r,
    input  logic [PIX_W-1:0] cfg_lvl_gr,
    input  logic [PIX_W-1:0] cfg_lvl_gb,
    input  logic [PIX_W-1:0] cfg_lvl_b,
    input  logic [PIX_W-1:0] s_tdata,
    input  logic             s_tvalid,
    output logic             s_tready,
    input  logic             s_tuser,
    input  logic             s_tlast,
    output logic [PIX_W-1:0] m_tdata,
    output logic             m_tvalid,
    input  logic             m_tready,
    output logic             m_tuser,
    output logic             m_tlast
);
    localparam int DIFF_W = PIX_W + 1;

    typedef struct packed {
        logic             valid;
        logic             user;
        logic             last;
        logic [PIX_W-1:0] data;
    } stage_t;

    stage_t st_d, st_q;
    logic             accept;
    logic             row_par, col_par;
    logic [PIX_W-1:0] level;
    logic [DIFF_W-1:0] diff;
    logic [PIX_W-1:0] corrected;

    assign s_tready = !st_q.valid || m_tready;
    assign accept   = s_tvalid && s_tready;

    bbs_position #(.DIM_W(DIM_W)) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .sof        (s_tuser),
        .cfg_width  (cfg_width),
        .cfg_height (cfg_height),
        .row_par    (row_par),
        .col_par    (col_par)
    );

    bbs_site_pick #(.PIX_W(PIX_W)) u_pick (
        .pattern (cfg_pattern),
        .row_par (row_par),
        .col_par (col_par),
        .lvl_r   (cfg_lvl_r),
        .lvl_gr  (cfg_lvl_gr),
        .lvl_gb  (cfg_lvl_gb),
        .lvl_b   (cfg_lvl_b),
        .level   (level)
    );

    always_comb begin
        diff      = {1'b0, s_tdata} - {1'b0, level};
        corrected = diff[PIX_W] ? '0 : diff[PIX_W-1:0];
        st_d      = st_q;
        if (accept) begin
            st_d.valid = 1'b1;
            st_d.user  = s_tuser;
            st_d.last  = s_tlast;
            st_d.data  = corrected;
        end else if (m_tready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign m_tvalid = st_q.valid;
    assign m_tdata  = st_q.data;
    assign m_tuser  = st_q.user;
    assign m_tlast  = st_q.last;

    // R1: output empty coming out of reset
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> !m_tvalid);

    // R8: a stalled output holds still
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready)
        |=> (m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast)));

    // R8: an accepted pixel is presented on the next cycle
    assert_no_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> m_tvalid);

    // R2: subtraction never raises a pixel
    assert_not_above_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (m_tdata <= $past(s_tdata)));

    // R5: zero offsets pass pixels through unchanged
    assert_identity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cfg_lvl_r == '0 && cfg_lvl_gr == '0 && cfg_lvl_gb == '0 && cfg_lvl_b == '0)
        |=> (m_tdata == $past(s_tdata)));

endmodule

// File: tb/bayer_black_sub_test.sv
module bayer_black_sub_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_width = 16'd4, cfg_height = 16'd4;
    logic [1:0]  cfg_pattern = 2'd0;
    logic [9:0]  cfg_lvl_r = '0, cfg_lvl_gr = '0, cfg_lvl_gb = '0, cfg_lvl_b = '0;
    logic [9:0]  s_tdata = '0;
    logic        s_tvalid = 1'b0, s_tuser = 1'b0, s_tlast = 1'b0;
    logic        s_tready;
    logic [9:0]  m_tdata;
    logic        m_tvalid, m_tuser, m_tlast;
    logic        m_tready = 1'b1;

    int compared = 0, mismatched = 0;
    string cur_req = "R2";
    bit gap_en = 0, bp_en = 0;
    logic [11:0] expq[$];
    int mrow = 0, mcol = 0;
    bit hold_pend = 0;
    logic [11:0] held;

    always #2 clk = ~clk;

    bayer_black_sub uut (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_pattern(cfg_pattern), .cfg_lvl_r(cfg_lvl_r), .cfg_lvl_gr(cfg_lvl_gr),
        .cfg_lvl_gb(cfg_lvl_gb), .cfg_lvl_b(cfg_lvl_b), .s_tdata(s_tdata),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tuser(s_tuser), .s_tlast(s_tlast),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tuser(m_tuser), .m_tlast(m_tlast)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Site table per R4, written as names per pattern and index {row[0],col[0]}
    function automatic logic [9:0] site_level(int pat, int r, int c);
        int idx = (r % 2) * 2 + (c % 2);
        string s;
        case (pat)
            0: s = (idx == 0) ? "R"  : (idx == 1) ? "Gr" : (idx == 2) ? "Gb" : "B";
            1: s = (idx == 0) ? "Gr" : (idx == 1) ? "R"  : (idx == 2) ? "B"  : "Gb";
            2: s = (idx == 0) ? "Gb" : (idx == 1) ? "B"  : (idx == 2) ? "R"  : "Gr";
            default: s = (idx == 0) ? "B" : (idx == 1) ? "Gb" : (idx == 2) ? "Gr" : "R";
        endcase
        if (s == "R")  return cfg_lvl_r;
        if (s == "Gr") return cfg_lvl_gr;
        if (s == "Gb") return cfg_lvl_gb;
        return cfg_lvl_b;
    endfunction

    function automatic logic [9:0] expect_pix(logic [9:0] d, logic [9:0] lvl);
        return (lvl >= d) ? 10'd0 : d - lvl;
    endfunction

    task automatic model_push(logic [9:0] d, logic u, logic l);
        int r, c;
        r = u ? 0 : mrow;
        c = u ? 0 : mcol;
        expq.push_back({u, l, expect_pix(d, site_level(cfg_pattern, r, c))});
        c++;
        if (c >= cfg_width) begin
            c = 0;
            r++;
            if (r >= cfg_height) r = 0;
        end
        mrow = r;
        mcol = c;
    endtask

    task automatic check_out();
        logic [11:0] e;
        if (hold_pend) begin
            check("R8 stall valid", m_tvalid, 1);
            check("R8 stall beat", {m_tuser, m_tlast, m_tdata}, held);
        end
        hold_pend = m_tvalid && !m_tready;
        held = {m_tuser, m_tlast, m_tdata};
        check("R8 ready rule", s_tready, !m_tvalid || m_tready);
        if (m_tvalid && m_tready) begin
            if (expq.size() == 0) begin
                check("R8 extra beat", 1, 0);
            end else begin
                e = expq.pop_front();
                check(cur_req, m_tdata, e[9:0]);
                check("R9 sideband", {m_tuser, m_tlast}, e[11:10]);
            end
        end
    endtask

    task automatic cycle(bit want, logic [9:0] d, logic u, logic l, output bit taken);
        @(negedge clk);
        s_tdata = d; s_tuser = u; s_tlast = l;
        s_tvalid = want && (!gap_en || ($urandom % 4) != 0);
        m_tready = bp_en ? (($urandom % 3) != 0) : 1'b1;
        #1;
        check_out();
        taken = s_tvalid && s_tready;
        if (taken) model_push(d, u, l);
    endtask

    task automatic push_pixel(logic [9:0] d, logic u, logic l);
        bit taken = 0;
        while (!taken) cycle(1'b1, d, u, l, taken);
    endtask

    task automatic drain();
        bit taken;
        for (int i = 0; i < 12; i++) cycle(1'b0, '0, 1'b0, 1'b0, taken);
        check("R8 all delivered", expq.size(), 0);
    endtask

    // mode 0: random data, mode 1: constant value
    task automatic send_rows(int w, int rows, bit sof, int mode, logic [9:0] val);
        for (int r = 0; r < rows; r++)
            for (int c = 0; c < w; c++)
                push_pixel(mode == 1 ? val : 10'($urandom), sof && r == 0 && c == 0, c == w - 1);
    endtask

    task automatic set_levels(logic [9:0] a, logic [9:0] b, logic [9:0] c, logic [9:0] d);
        cfg_lvl_r = a; cfg_lvl_gr = b; cfg_lvl_gb = c; cfg_lvl_b = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected finish");
        mismatched++;
        compared++;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 valid in reset", m_tvalid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", m_tvalid, 0);

        cur_req = "R5";
        set_levels(0, 0, 0, 0);
        cfg_width = 6; cfg_height = 4;
        send_rows(6, 4, 1, 0, 0);
        drain();

        cur_req = "R2";
        set_levels(10, 10, 10, 10);
        cfg_width = 4; cfg_height = 2;
        send_rows(4, 2, 1, 1, 10'd28);
        drain();
        gap_en = 1; bp_en = 1;
        for (int f = 0; f < 20; f++) begin
            set_levels(10'($urandom % 300), 10'($urandom % 300), 10'($urandom % 300), 10'($urandom % 300));
            cfg_pattern = 2'($urandom);
            cfg_width = 16'(2 + $urandom % 9);
            cfg_height = 16'(1 + $urandom % 6);
            send_rows(cfg_width, cfg_height, 1, 0, 0);
            drain();
        end

        cur_req = "R4";
        set_levels(100, 200, 300, 400);
        cfg_width = 4; cfg_height = 4;
        for (int p = 0; p < 4; p++) begin
            cfg_pattern = 2'(p);
            send_rows(4, 4, 1, 1, 10'd1000);
            drain();
        end

        cur_req = "R3";
        set_levels(1023, 600, 5, 512);
        cfg_pattern = 2'd0;
        send_rows(4, 4, 1, 0, 0);
        send_rows(4, 1, 1, 1, 10'd5);
        send_rows(4, 2, 1, 1, 10'd512);
        drain();

        cur_req = "R6";
        set_levels(1, 2, 3, 4);
        cfg_width = 5; cfg_height = 3;
        send_rows(3, 1, 1, 0, 0);
        send_rows(5, 3, 1, 1, 10'd50);
        push_pixel(10'd50, 0, 0);
        push_pixel(10'd50, 0, 0);
        send_rows(5, 2, 1, 1, 10'd50);
        drain();

        cur_req = "R7";
        cfg_width = 3; cfg_height = 3;
        cfg_pattern = 2'd1;
        send_rows(3, 10, 1, 1, 10'd50);
        drain();

        cur_req = "R8";
        gap_en = 1; bp_en = 1;
        set_levels(7, 9, 11, 13);
        cfg_width = 8; cfg_height = 8;
        send_rows(8, 8, 1, 0, 0);
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule